// File: doc/BRIEF.md
# High/Low Time Programmable Clock Divider

This block derives a slower clock from its input clock. The output high phase and the output low phase each have their own count of input cycles, so the period and the duty cycle are set independently. An optional half-cycle adjust moves the high-to-low transition onto the falling edge of the input clock. This gives half-cycle resolution on the duty cycle.

After reset, or after the block is enabled, a start delay in input cycles sets a coarse phase offset. A bypass setting passes the input clock straight through. The divide setting can also be changed while the output runs, through a request/done handshake. The new setting takes effect only at a period boundary, so no shortened pulse appears.

All configuration inputs are plain control levels. The block has no data stream, so there is no back-pressure. The request/done pair is the only handshake: the request is a level sampled on rising edges, and done is a single-cycle pulse.

Top module: `clkdiv_hl`

## Requirements
- R1: With enable high and bypass low, the output repeats a pattern of `cfg_high` input cycles high followed by `cfg_low` input cycles low, with transitions on rising input edges when the half adjust is off.
- R2: A count field of 0 on `cfg_high` or `cfg_low` means 64 input cycles.
- R3: Counting from the first rising edge at which enable is high, with bypass low and the counter held before it, the first high phase starts at rising edge number `cfg_delay`+1. The output is low before that edge.
- R4: With `cfg_half` set, each high-to-low transition is moved half an input cycle later, onto the following falling edge. The high phase then lasts `cfg_high`+½ cycles and the low phase `cfg_low`−½ cycles. The low-to-high transition is unchanged.
- R5: While `cfg_en` is low, the output is low and the sequence is held at its start. Raising enable again restarts from the start delay (R3).
- R6: With `cfg_en` high and `cfg_bypass` set, the output equals the input clock.
- R7: With `cfg_dyn` set, a `chg_req` seen on a rising edge captures the `cfg_high`, `cfg_low` and `cfg_half` values at that edge. The captured setting is applied at the edge that ends the current low phase, so the next high phase uses it. `chg_done` is high for exactly the one cycle that follows that edge.
- R8: While the divider runs, changes on `cfg_high`, `cfg_low` or `cfg_half` made without the handshake do not alter the waveform. They are taken up only while the divider is held or waiting out its start delay.
- R9: A `chg_req` while `cfg_dyn` is low is ignored: no `chg_done` pulse follows and the waveform keeps its setting.
- R10: During reset the output is low and `chg_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Divider enable; when low the output is held low |
| cfg_bypass | input | 1 | Pass the input clock straight to the output |
| cfg_high | input | 6 | High-phase length in input cycles (0 means 64) |
| cfg_low | input | 6 | Low-phase length in input cycles (0 means 64) |
| cfg_half | input | 1 | Move the falling transition half a cycle later |
| cfg_delay | input | 6 | Start delay in input cycles before the first high phase |
| cfg_dyn | input | 1 | Allow divide changes through the handshake |
| chg_req | input | 1 | Request to apply the current high/low/half values while running |
| chg_done | output | 1 | One-cycle pulse once the requested setting is applied |
| clk_out | output | 1 | Divided output clock |

## Verification
The main check sweeps every high and low count from 1 to 5, with the half adjust off and on and with start delays of 0 and 2. The output is sampled in both halves of every input cycle against an arithmetic pattern. This separates errors in phase length, in the first-edge offset and in the half-cycle extension. Two runs with a count of 0 confirm the 64-cycle reading, which small counts cannot distinguish from a wrap bug. Mid-run changes are tried three ways: with the handshake, without it, and as a request while the change enable is off. This separates the boundary-aligned update from the two cases that must leave the waveform unchanged.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Sequencer phase: start-delay wait, high phase, low phase
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] act_high,
  input  logic [CNT_W-1:0] act_low,
  output phase_e           phase,
  output logic             q_pos,
  output logic             low_end,
  output logic             idle
);
  localparam int unsigned CW     = CNT_W + 1;
  localparam int unsigned FULL_I = 1 << CNT_W;
  localparam logic [CW-1:0] FULL = FULL_I[CW-1:0];
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt, cnt_n;
  phase_e        ph_n;

  // A zero count field stands for the full range
  function automatic logic [CW-1:0] eff(input logic [CNT_W-1:0] v);
    eff = (v == '0) ? FULL : {1'b0, v};
  endfunction

  always_comb begin
    ph_n    = phase;
    cnt_n   = cnt;
    low_end = 1'b0;
    if (!run) begin
      ph_n  = PH_WAIT;
      cnt_n = '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (cnt == {1'b0, delay}) begin
            ph_n  = PH_HIGH;
            cnt_n = ONE;
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        PH_HIGH: begin
          if (cnt == eff(act_high)) begin
            ph_n  = PH_LOW;
            cnt_n = ONE;
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        PH_LOW: begin
          if (cnt == eff(act_low)) begin
            ph_n    = PH_HIGH;
            cnt_n   = ONE;
            low_end = 1'b1;
          end else begin
            cnt_n = cnt + ONE;
          end
        end
        default: begin
          ph_n  = PH_WAIT;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
      cnt   <= '0;
      q_pos <= 1'b0;
    end else begin
      phase <= ph_n;
      cnt   <= cnt_n;
      q_pos <= (ph_n == PH_HIGH);
    end
  end

  assign idle = (phase == PH_WAIT);
endmodule

// File: rtl/clkdiv_set.sv
`timescale 1ns/1ps
module clkdiv_set #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_half,
  input  logic             cfg_dyn,
  input  logic             chg_req,
  input  logic             idle,
  input  logic             low_end,
  output logic [CNT_W-1:0] act_high,
  output logic [CNT_W-1:0] act_low,
  output logic             act_half,
  output logic             pending,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] sh_high, sh_low;
  logic             sh_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_high <= CNT_ONE;
      act_low  <= CNT_ONE;
      act_half <= 1'b0;
      sh_high  <= CNT_ONE;
      sh_low   <= CNT_ONE;
      sh_half  <= 1'b0;
      pending  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      // Held or in start delay: the live setting is taken up directly
      if (idle) begin
        act_high <= cfg_high;
        act_low  <= cfg_low;
        act_half <= cfg_half;
      end
      if (!pending && cfg_dyn && chg_req) begin
        pending <= 1'b1;
        sh_high <= cfg_high;
        sh_low  <= cfg_low;
        sh_half <= cfg_half;
      end
      // Apply only at the low-to-high period boundary
      if (pending && low_end) begin
        act_high <= sh_high;
        act_low  <= sh_low;
        act_half <= sh_half;
        pending  <= 1'b0;
        done     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_outstage.sv
`timescale 1ns/1ps
module clkdiv_outstage #(
  parameter bit HALF_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bypass,
  input  logic half,
  input  logic q_pos,
  output logic clk_out
);
  logic ext;

  generate
    if (HALF_EDGE) begin : g_half
      logic q_neg;
      // Falling-edge copy stretches each high phase by half a cycle
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q_neg <= 1'b0;
        else        q_neg <= q_pos;
      end
      assign ext = q_pos | (half & q_neg);
    end else begin : g_plain
      logic unused_half;
      assign unused_half = half;
      assign ext = q_pos;
    end
  endgenerate

  assign clk_out = en & (bypass ? clk : ext);
endmodule

// File: rtl/clkdiv_hl.sv
`timescale 1ns/1ps
module clkdiv_hl
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W     = 6,
  parameter bit          HALF_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bypass,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_half,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic             cfg_dyn,
  input  logic             chg_req,
  output logic             chg_done,
  output logic             clk_out
);
  phase_e           phase_w;
  logic             q_pos_w, low_end_w, idle_w, pend_w, run_w;
  logic [CNT_W-1:0] act_high_w, act_low_w;
  logic             act_half_w;

  assign run_w = cfg_en & ~cfg_bypass;

  clkdiv_set #(.CNT_W(CNT_W)) u_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_high (cfg_high),
    .cfg_low  (cfg_low),
    .cfg_half (cfg_half),
    .cfg_dyn  (cfg_dyn),
    .chg_req  (chg_req),
    .idle     (idle_w),
    .low_end  (low_end_w),
    .act_high (act_high_w),
    .act_low  (act_low_w),
    .act_half (act_half_w),
    .pending  (pend_w),
    .done     (chg_done)
  );

  clkdiv_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .delay    (cfg_delay),
    .act_high (act_high_w),
    .act_low  (act_low_w),
    .phase    (phase_w),
    .q_pos    (q_pos_w),
    .low_end  (low_end_w),
    .idle     (idle_w)
  );

  clkdiv_outstage #(.HALF_EDGE(HALF_EDGE)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_en),
    .bypass  (cfg_bypass),
    .half    (act_half_w),
    .q_pos   (q_pos_w),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/clkdiv_hl_chk.sv
`timescale 1ns/1ps
module clkdiv_hl_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dyn,
  input logic             clk_out,
  input logic             chg_done,
  input logic             pending,
  input phase_e           phase,
  input logic [CNT_W-1:0] act_high,
  input logic [CNT_W-1:0] act_low,
  input logic             act_half
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_done |=> !chg_done);

  assert_done_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_done |-> $past(pending));

  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !clk_out);

  assert_setting_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$stable(act_high) || !$stable(act_low) || !$stable(act_half))
      && ($past(phase) != PH_WAIT)) |-> chg_done);

  assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn && !pending) |=> !pending);
endmodule

bind clkdiv_hl clkdiv_hl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (cfg_en),
  .dyn      (cfg_dyn),
  .clk_out  (clk_out),
  .chg_done (chg_done),
  .pending  (pend_w),
  .phase    (phase_w),
  .act_high (act_high_w),
  .act_low  (act_low_w),
  .act_half (act_half_w)
);

// File: tb/sim_clkdiv_hl.sv
`timescale 1ns/1ps
module sim_clkdiv_hl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_bypass = 1'b0, cfg_half = 1'b0;
  logic       cfg_dyn = 1'b0, chg_req = 1'b0;
  logic [5:0] cfg_high = 6'd1, cfg_low = 6'd1, cfg_delay = 6'd0;
  logic       chg_done, clk_out;
  int         nchk = 0, nfail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_hl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bypass(cfg_bypass),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_half(cfg_half),
    .cfg_delay(cfg_delay), .cfg_dyn(cfg_dyn), .chg_req(chg_req),
    .chg_done(chg_done), .clk_out(clk_out)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  // Ideal level after rising edge k (k=1 is the first edge with enable)
  function automatic logic pexp(int k, int ht, int lt, int dt);
    int h, l;
    h = (ht == 0) ? 64 : ht;
    l = (lt == 0) ? 64 : lt;
    if (k < dt + 1) return 1'b0;
    return ((k - dt - 1) % (h + l)) < h;
  endfunction

  // mode 0: plain; 1: change high count mid-run without handshake;
  // 2: request while change enable is off
  task automatic run_cfg(input int ht, input int lt, input bit half,
                         input int dt, input int n, input int mode,
                         input string tag);
    @(posedge clk); #2;
    cfg_en = 1'b0; cfg_bypass = 1'b0; cfg_dyn = 1'b0; chg_req = 1'b0;
    cfg_high = 6'(ht); cfg_low = 6'(lt); cfg_half = half; cfg_delay = 6'(dt);
    @(posedge clk); #2;
    @(posedge clk); #2;
    cfg_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1.25;
      chk(clk_out, pexp(k, ht, lt, dt) | (half & pexp(k - 1, ht, lt, dt)), tag);
      if (mode == 2) chk(chg_done, 1'b0, "R9");
      #2.5;
      chk(clk_out, pexp(k, ht, lt, dt), tag);
      if (mode == 1 && k == 5) begin
        cfg_high = 6'(ht + 3); cfg_low = 6'(lt + 1); cfg_half = ~half;
      end
      if (mode == 2 && k == 5) chg_req = 1'b1;
      if (mode == 2 && k == 6) chg_req = 1'b0;
    end
    // R5: disabled output stays low in both halves
    cfg_en = 1'b0;
    @(posedge clk); #1.25;
    chk(clk_out, 1'b0, "R5");
    #2.5;
    chk(clk_out, 1'b0, "R5");
  endtask

  task automatic run_dyn();
    logic p;
    @(posedge clk); #2;
    cfg_en = 1'b0; cfg_bypass = 1'b0; cfg_dyn = 1'b1; chg_req = 1'b0;
    cfg_high = 6'd2; cfg_low = 6'd2; cfg_half = 1'b0; cfg_delay = 6'd0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    cfg_en = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk); #1.25;
      // Old 2/2 pattern up to edge 8, new 3/1 pattern from edge 9
      p = (k <= 8) ? (((k - 1) % 4) < 2) : (((k - 9) % 4) < 3);
      chk(clk_out, p, "R7");
      chk(chg_done, (k == 9), "R7");
      #2.5;
      if (k == 5) begin
        cfg_high = 6'd3; cfg_low = 6'd1; chg_req = 1'b1;
      end
      if (k == 6) chg_req = 1'b0;
    end
    cfg_en = 1'b0; cfg_dyn = 1'b0;
  endtask

  initial begin
    #1;
    cfg_en = 1'b1;
    #10;
    chk(clk_out, 1'b0, "R10");
    chk(chg_done, 1'b0, "R10");
    #2.3;
    chk(clk_out, 1'b0, "R10");
    rst_n = 1'b1;

    // R1 R3 R4 sweep
    for (int dt = 0; dt <= 2; dt += 2)
      for (int hf = 0; hf < 2; hf++)
        for (int ht = 1; ht <= 5; ht++)
          for (int lt = 1; lt <= 5; lt++)
            run_cfg(ht, lt, hf[0], dt, dt + 3 * (ht + lt) + 2, 0, "R1 R3 R4");

    // R2: zero counts mean 64
    run_cfg(0, 3, 1'b0, 1, 140, 0, "R2");
    run_cfg(2, 0, 1'b1, 0, 140, 0, "R2");

    // R8: setting change without handshake
    run_cfg(2, 3, 1'b0, 0, 30, 1, "R8");
    // R9: request with change enable off
    run_cfg(3, 2, 1'b1, 0, 30, 2, "R9");

    // R6: bypass
    @(posedge clk); #2;
    cfg_en = 1'b1; cfg_bypass = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1.25;
      chk(clk_out, 1'b1, "R6");
      #2.5;
      chk(clk_out, 1'b0, "R6");
    end
    cfg_bypass = 1'b0; cfg_en = 1'b0;

    // R7: handshaked change
    run_dyn();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule